// File: doc/BRIEF.md
# Two-Level Pending Interrupt Controller

This block gathers a parameterised number of level-sensitive interrupt lines and turns them into the two request lines of a processor core: a normal request (`irq_o`) and a fast request (`fiq_o`). Every asserted line is latched into a source-pending register, including lines that are masked. A source that is unmasked and set for the normal path is a candidate. A fixed-priority arbiter picks one candidate and records it in a one-hot interrupt-pending register. It also records the winner's binary index in a read-only offset register, so a handler can jump to the right routine without scanning bits.

Software reaches five word addresses through a simple register port. A write takes effect on the clock edge where `reg_wr` is high. A read is combinational from `reg_addr`. A pending condition is retired in two steps. First, software writes 1 to the source-pending bit. Then it writes 1 to the interrupt-pending bit. Writing 0 to either pending register changes nothing. Sources whose mode bit selects the fast path never enter arbitration. They drive `fiq_o` directly while they are pending and unmasked.

The arbiter is a two-state machine. In `ARB_SCAN`, interrupt-pending is empty. If any candidate exists, the transition `scan->hold` loads the lowest-index candidate on the next edge. In `ARB_HOLD`, the winner is frozen. A write of 1 to its interrupt-pending bit takes the transition `hold->scan`, which empties the register. A new winner can then be loaded one edge later. No other transitions exist.

Top module: `pend_intc`

## Requirements
- R1: After reset, the mask register reads all ones. The source-pending, mode, interrupt-pending and offset registers read zero, and both `irq_o` and `fiq_o` are low.
- R2: A source line high at a clock edge sets its source-pending bit at that edge, whether the source is masked or not. The bit stays set after the line falls.
- R3: Writing 1 to a source-pending bit (address 0) clears it, unless its line is high at that same edge. Writing 0 leaves the bit unchanged.
- R4: The mask register (address 1) is read/write, and 1 means disabled. A masked source never enters interrupt-pending and never raises `fiq_o`.
- R5: When interrupt-pending is empty, the next edge loads it with a one-hot code of the lowest-index source that is source-pending, unmasked and in normal mode. At most one interrupt-pending bit is ever set.
- R6: While interrupt-pending is nonzero, it keeps its value until software clears its set bit. New or higher-priority requests do not replace it.
- R7: Writing 1 to the set interrupt-pending bit (address 3) empties the register at that edge. Writing 0 has no effect. A candidate still present is loaded at the following edge.
- R8: `irq_o` is high exactly while interrupt-pending is nonzero.
- R9: The mode register (address 2) is read/write, and bit value 1 selects the fast path. `fiq_o` is high while any source is source-pending, unmasked and in fast mode. Such sources never enter interrupt-pending.
- R10: The offset register (address 4) reads the binary index of the set interrupt-pending bit, zero-extended. It reads zero while interrupt-pending is empty.
- R11: Writes to address 4 are ignored. Addresses 5 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Level-sensitive source lines |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Normal interrupt request level |
| fiq_o | output | 1 | Fast interrupt request level |

## Verification
The bench goes after the cases where a higher-priority request arrives while a winner is in service. A design that re-arbitrates at that point would swap the one-hot bit under the running handler. It also targets the clearing order. If only interrupt-pending is cleared, the still-latched source must win again one cycle later. A design that drops the one-cycle gap, or that ignores source-pending, would show a different interrupt-pending value in that cycle. Masked and fast-mode sources are checked to stay latched in source-pending while staying out of interrupt-pending. A design that gates the latch by the mask, or that lets fast sources into arbitration, shows a wrong read value or a spurious `irq_o`. Writes of 0 and writes to the offset address are checked to change nothing.

// File: rtl/pend_intc_pkg.sv
package pend_intc_pkg;

    // register word addresses
    localparam logic [2:0] ADDR_SRCPND = 3'd0;
    localparam logic [2:0] ADDR_MASK   = 3'd1;
    localparam logic [2:0] ADDR_MODE   = 3'd2;
    localparam logic [2:0] ADDR_INTPND = 3'd3;
    localparam logic [2:0] ADDR_OFFSET = 3'd4;

    // arbiter state machine
    typedef enum logic [0:0] {
        ARB_SCAN = 1'b0,  // interrupt-pending empty, looking for a winner
        ARB_HOLD = 1'b1   // winner latched, waiting for software clear
    } arb_state_e;

endpackage

// File: rtl/pend_intc_cfg.sv
module pend_intc_cfg #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] srcpnd,
    output logic [NSRC-1:0] mask,
    output logic [NSRC-1:0] mode
);
    import pend_intc_pkg::*;

    logic [NSRC-1:0] src_clr;
    logic            mask_we;
    logic            mode_we;

    always_comb begin
        src_clr = (reg_wr && reg_addr == ADDR_SRCPND) ? reg_wdata : '0;
        mask_we = reg_wr && reg_addr == ADDR_MASK;
        mode_we = reg_wr && reg_addr == ADDR_MODE;
    end

    // source-pending: write-1-to-clear, a live request wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srcpnd <= '0;
        end else begin
            srcpnd <= (srcpnd & ~src_clr) | src_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '1;
            mode <= '0;
        end else begin
            if (mask_we) mask <= reg_wdata;
            if (mode_we) mode <= reg_wdata;
        end
    end

    AST_SRC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != '0) |=> ((srcpnd & $past(src_req)) == $past(src_req))); // R2

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_SRCPND) |=>
        ((srcpnd & ~$past(reg_wdata)) == ($past(srcpnd) & ~$past(reg_wdata)) | ($past(src_req) & ~$past(reg_wdata)))); // R3

endmodule

// File: rtl/pend_intc_prio.sv
module pend_intc_prio #(
    parameter int NSRC = 8,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] req,
    output logic [NSRC-1:0] grant,
    output logic [IDXW-1:0] index
);
    // found[i] is high when any request below index i is present
    logic [NSRC-1:0] found;

    assign found[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 1; gi < NSRC; gi++) begin : g_chain
            assign found[gi] = found[gi-1] | req[gi-1];
        end
    endgenerate

    assign grant = req & ~found;

    always_comb begin
        index = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) index = index | IDXW'(i);
        end
    end

endmodule

// File: rtl/pend_intc_arb.sv
module pend_intc_arb #(
    parameter int NSRC = 8,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cand,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_data,
    output logic [NSRC-1:0] intpnd,
    output logic [IDXW-1:0] offset
);
    import pend_intc_pkg::*;

    arb_state_e      st_q, st_d;
    logic            load_win;
    logic            drop_win;
    logic [NSRC-1:0] win_hot;
    logic [IDXW-1:0] win_idx;

    pend_intc_prio #(.NSRC(NSRC)) u_prio (
        .req   (cand),
        .grant (win_hot),
        .index (win_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARB_SCAN;
        else        st_q <= st_d;
    end

    // transitions: scan->hold on a candidate, hold->scan on a clear of the winner
    always_comb begin
        st_d     = st_q;
        load_win = 1'b0;
        drop_win = 1'b0;
        unique case (st_q)
            ARB_SCAN: begin
                if (cand != '0) begin
                    st_d     = ARB_HOLD;
                    load_win = 1'b1;
                end
            end
            ARB_HOLD: begin
                if (clr_wr && ((intpnd & clr_data) != '0)) begin
                    st_d     = ARB_SCAN;
                    drop_win = 1'b1;
                end
            end
            default: st_d = ARB_SCAN;
        endcase
    end

    // outputs of the machine: winner and its offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intpnd <= '0;
            offset <= '0;
        end else if (load_win) begin
            intpnd <= win_hot;
            offset <= win_idx;
        end else if (drop_win) begin
            intpnd <= '0;
            offset <= '0;
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(intpnd)); // R5

    AST_WINNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (intpnd != '0 && !(clr_wr && (intpnd & clr_data) != '0)) |=> $stable(intpnd)); // R6

    AST_WIN_FROM_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (intpnd == '0) |=> ((intpnd & ~$past(cand)) == '0)); // R4

    AST_OFFSET_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (intpnd != '0) |-> intpnd[offset]); // R10

    AST_STATE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ARB_HOLD) == (intpnd != '0)); // R8

endmodule

// File: rtl/pend_intc.sv
module pend_intc #(
    parameter int NSRC = 8,
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    import pend_intc_pkg::*;

    logic [NSRC-1:0] srcpnd;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] mode;
    logic [NSRC-1:0] intpnd;
    logic [IDXW-1:0] offset;
    logic [NSRC-1:0] irq_cand;
    logic [NSRC-1:0] fiq_live;
    logic            ip_wr;

    pend_intc_cfg #(.NSRC(NSRC)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req   (src_req),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .srcpnd    (srcpnd),
        .mask      (mask),
        .mode      (mode)
    );

    assign irq_cand = srcpnd & ~mask & ~mode;
    assign fiq_live = srcpnd & ~mask & mode;
    assign ip_wr    = reg_wr && reg_addr == ADDR_INTPND;

    pend_intc_arb #(.NSRC(NSRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand     (irq_cand),
        .clr_wr   (ip_wr),
        .clr_data (reg_wdata),
        .intpnd   (intpnd),
        .offset   (offset)
    );

    always_comb begin
        case (reg_addr)
            ADDR_SRCPND: reg_rdata = srcpnd;
            ADDR_MASK:   reg_rdata = mask;
            ADDR_MODE:   reg_rdata = mode;
            ADDR_INTPND: reg_rdata = intpnd;
            ADDR_OFFSET: reg_rdata = NSRC'(offset);
            default:     reg_rdata = '0;
        endcase
    end

    assign irq_o = intpnd != '0;
    assign fiq_o = fiq_live != '0;

    AST_FIQ_NOT_ARBITRATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((intpnd & mode) != '0) |-> $past(intpnd != '0)); // R9

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(srcpnd & ~mask) != '0)); // R8

endmodule

// File: tb/sim_pend_intc.sv
`timescale 1ns/1ps
module sim_pend_intc;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_req = '0;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         irq_o;
    logic         fiq_o;

    always #2.5 clk = ~clk;

    pend_intc #(.NSRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [N-1:0] m_src, m_msk, m_mod, m_ip, m_off;

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
        return '0;
    endfunction

    function automatic logic [N-1:0] idx_of(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return N'(i);
        return '0;
    endfunction

    function automatic logic [N-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_src;
            3'd1: return m_msk;
            3'd2: return m_mod;
            3'd3: return m_ip;
            3'd4: return m_off;
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2 srcpnd";
            3'd1: return "R4 mask";
            3'd2: return "R9 mode";
            3'd3: return "R5 intpnd";
            3'd4: return "R10 offset";
            default: return "R11 unused addr";
        endcase
    endfunction

    task automatic model_reset();
        m_src = '0; m_msk = '1; m_mod = '0; m_ip = '0; m_off = '0;
    endtask

    // one cycle: drive at negedge, check mid-cycle, advance model at the edge
    task automatic step(input logic [N-1:0] rq, input logic wr, input logic [2:0] a,
                        input logic [N-1:0] wd, input logic use_exp,
                        input logic [N-1:0] exp, input string tag);
        logic [N-1:0] cand, n_src, n_msk, n_mod, n_ip, n_off;
        src_req = rq; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        chk(tag_of(a), reg_rdata, model_read(a));
        if (use_exp) chk(tag, reg_rdata, exp);
        chk("R8 irq", N'(irq_o), N'(m_ip != '0));
        chk("R9 fiq", N'(fiq_o), N'((m_src & ~m_msk & m_mod) != '0));
        cand  = m_src & ~m_msk & ~m_mod;
        n_src = (m_src & ~((wr && a == 3'd0) ? wd : '0)) | rq;
        n_msk = (wr && a == 3'd1) ? wd : m_msk;
        n_mod = (wr && a == 3'd2) ? wd : m_mod;
        n_ip = m_ip; n_off = m_off;
        if (m_ip == '0) begin
            if (cand != '0) begin n_ip = lowest(cand); n_off = idx_of(cand); end
        end else if (wr && a == 3'd3 && (m_ip & wd) != '0) begin
            n_ip = '0; n_off = '0;
        end
        m_src = n_src; m_msk = n_msk; m_mod = n_mod; m_ip = n_ip; m_off = n_off;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [2:0] a, input logic [N-1:0] exp, input string tag);
        step('0, 1'b0, a, '0, 1'b1, exp, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        step('0, 1'b1, a, d, 1'b0, '0, "");
    endtask

    task automatic idle(input logic [N-1:0] rq);
        step(rq, 1'b0, 3'd0, '0, 1'b0, '0, "");
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        peek(3'd0, 8'h00, "R1 srcpnd reset");
        peek(3'd1, 8'hFF, "R1 mask reset");
        peek(3'd2, 8'h00, "R1 mode reset");
        peek(3'd3, 8'h00, "R1 intpnd reset");
        peek(3'd4, 8'h00, "R1 offset reset");
        chk("R1 irq reset", N'(irq_o), '0);
        chk("R1 fiq reset", N'(fiq_o), '0);

        // R2 masked source still latches, R4 no win
        idle(8'h20);
        peek(3'd0, 8'h20, "R2 masked latch");
        peek(3'd3, 8'h00, "R4 masked no intpnd");
        chk("R4 masked no irq", N'(irq_o), '0);

        // R3 write-zero ignored, write-one clears
        wr(3'd0, 8'h00);
        peek(3'd0, 8'h20, "R3 write zero");
        wr(3'd0, 8'h20);
        peek(3'd0, 8'h00, "R3 write one");

        // R5 arbitration, R10 offset, R6 hold, R7 clear order
        wr(3'd1, 8'h00);
        idle(8'h20);
        idle('0);
        peek(3'd3, 8'h20, "R5 winner");
        peek(3'd4, 8'h05, "R10 offset");
        idle(8'h02);
        idle('0);
        peek(3'd3, 8'h20, "R6 not displaced");
        wr(3'd0, 8'h20);
        wr(3'd3, 8'h00);
        peek(3'd3, 8'h20, "R7 write zero");
        wr(3'd3, 8'h20);
        peek(3'd3, 8'h00, "R7 cleared");
        peek(3'd3, 8'h02, "R7 next winner");
        peek(3'd4, 8'h01, "R10 offset next");

        // R9 fast path
        wr(3'd0, 8'h02);
        wr(3'd3, 8'h02);
        idle('0);
        wr(3'd2, 8'h80);
        idle(8'h80);
        chk("R9 fiq raised", N'(fiq_o), N'(1));
        peek(3'd3, 8'h00, "R9 no intpnd");
        chk("R9 no irq", N'(irq_o), '0);
        wr(3'd1, 8'h80);
        chk("R4 masked fiq", N'(fiq_o), '0);

        // R11 offset read-only, unused address
        wr(3'd4, 8'hFF);
        peek(3'd4, 8'h00, "R11 offset write ignored");
        wr(3'd6, 8'hFF);
        peek(3'd6, 8'h00, "R11 unused reads zero");
        peek(3'd1, 8'h80, "R11 unused write ignored");

        // constrained random against the model
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] rq;
            logic         w;
            logic [2:0]   a;
            logic [N-1:0] d;
            rq = N'($urandom & $urandom & $urandom);
            w  = ($urandom % 10) < 3;
            a  = 3'($urandom % 8);
            d  = N'($urandom);
            if (w && a == 3'd1) d = d & N'($urandom);
            if (w && a == 3'd2) d = d & N'($urandom) & N'($urandom);
            step(rq, w, a, d, 1'b0, '0, "");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule